// File: doc/BRIEF.md
# Fixed-Length Static Memory Access Sequencer

This block lets a clocked host talk to an asynchronous static memory. The host hands over one request at a time: an address, write data and a direction flag. The sequencer then drives the memory's address, chip-enable, output-enable, write-strobe and data lines through a fixed number of clock cycles, called phases T1 to TN. At the end it raises a one-cycle completion pulse. For a read, the word it captured from the memory comes out with that pulse.

The access length N is computed at elaboration from three parameters: read access time, write cycle time and clock period. N is the ceiling of the larger of the two memory times divided by the period. It is never less than three, so that the write strobe always has a cycle before it and a cycle after it. With a 20 ns clock, a 65 ns access and a 75 ns write cycle, every access lasts four phases. In a write, the active-low strobe is low from T2 through T(N-1). This gives the address a full cycle of setup before the falling edge and a full cycle of hold after the rising edge. The write data is driven over all N phases, so it is valid well before the rising edge and held past it. In a read, the memory output is sampled at the clock edge that closes TN, once it has had the whole access time to settle.

Top module: `sram_seq`

## Requirements
- R1: The access length N equals ceil(max(read time, write time) / clock period), with a floor of 3. The default parameters give N = 4.
- R2: `ready` is high when idle. A request is taken on a clock edge where `req_valid` and `ready` are both high. `ready` then reads low from T1 through TN. A request presented while `ready` is low is ignored: the memory pins keep serving the accepted request, and no extra access follows.
- R3: In a write, `mem_we_n` is low in phases T2 to T(N-1) only. It is high in T1, in TN and whenever the sequencer is idle.
- R4: `mem_ce_n` is low during all N phases and high when idle. `mem_addr` equals the accepted address and does not change during the N phases.
- R5: In a write, `mem_dq_oe` is high in all N phases and `mem_dq_out` equals the accepted write data. In a read, and when idle, `mem_dq_oe` is low.
- R6: In a read, `mem_oe_n` is low in all N phases and `mem_we_n` stays high. `rd_data` takes the value `mem_dq_in` held at the clock edge that ends TN.
- R7: `done` is high for exactly one cycle: the cycle after TN, which is N clock edges after the accepting edge. `ready` is high again in that cycle. A write completion leaves `rd_data` unchanged.
- R8: After reset, `ready` is 1, `done` is 0, `rd_data` is 0, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| ready | output | 1 | Idle, able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read word |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_ce_n | output | 1 | Memory enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | DATA_W | Data driven to the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
Every memory pin is registered. Phase Tk is therefore visible in the k-th cycle after the accepting edge, and `done` with `rd_data` in cycle N+1. The bench samples each phase on the falling edge inside that cycle and compares it with a per-phase expectation built from its own computation of N. The bench's memory model returns a decoy word until the data has had N-1 phases to settle, so capturing before the end of TN shows up as wrong data. Writes reach the model only on the rising edge of the strobe, and later reads check what landed there.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  function automatic int cycles_needed(input int clk_ps, input int rd_ps, input int wr_ps);
    int worst;
    int n;
    worst = (rd_ps > wr_ps) ? rd_ps : wr_ps;
    n = (worst + clk_ps - 1) / clk_ps;
    return (n < 3) ? 3 : n;
  endfunction

  function automatic logic strobe_phase(input int phase, input int n);
    return (phase >= 2) && (phase <= n - 1);
  endfunction
endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int NCYC = 4,
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  output logic            busy,
  output logic [PH_W-1:0] phase,
  output logic            busy_nxt,
  output logic [PH_W-1:0] phase_nxt,
  output logic            last
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NCYC);

  always_comb begin
    busy_nxt  = busy;
    phase_nxt = phase;
    if (accept) begin
      busy_nxt  = 1'b1;
      phase_nxt = PH_W'(1);
    end else if (busy) begin
      if (phase == LAST_PH) begin
        busy_nxt  = 1'b0;
        phase_nxt = '0;
      end else begin
        phase_nxt = phase + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= '0;
    end else begin
      busy  <= busy_nxt;
      phase <= phase_nxt;
    end
  end

  assign last = busy && (phase == LAST_PH);
endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int NCYC   = 4,
  parameter int PH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              busy_nxt,
  input  logic [PH_W-1:0]   phase_nxt,
  output logic              op_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  logic wr_nxt;
  assign wr_nxt = accept ? req_write : op_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_write   <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
    end else begin
      op_write  <= wr_nxt;
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      mem_ce_n  <= !busy_nxt;
      mem_oe_n  <= !(busy_nxt && !wr_nxt);
      mem_we_n  <= !(busy_nxt && wr_nxt && strobe_phase(int'(phase_nxt), NCYC));
      mem_dq_oe <= busy_nxt && wr_nxt;
    end
  end
endmodule

// File: rtl/sram_seq_capture.sv
module sram_seq_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last,
  input  logic              op_write,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= last;
      if (last && !op_write) rd_data <= mem_dq_in;
    end
  end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int CLK_PS   = 20000,
  parameter int READ_PS  = 65000,
  parameter int WRITE_PS = 75000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  // R1: access length fixed at elaboration
  localparam int NCYC = cycles_needed(CLK_PS, READ_PS, WRITE_PS);
  localparam int PH_W = $clog2(NCYC + 1);

  logic            busy;
  logic [PH_W-1:0] phase;
  logic            busy_nxt;
  logic [PH_W-1:0] phase_nxt;
  logic            last_phase;
  logic            accept;
  logic            op_write;

  assign ready  = !busy;
  assign accept = req_valid && ready;

  sram_seq_timer #(.NCYC(NCYC), .PH_W(PH_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .busy(busy), .phase(phase), .busy_nxt(busy_nxt),
    .phase_nxt(phase_nxt), .last(last_phase)
  );

  sram_seq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCYC(NCYC), .PH_W(PH_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy_nxt(busy_nxt),
    .phase_nxt(phase_nxt), .op_write(op_write), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  sram_seq_capture #(.DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .last(last_phase), .op_write(op_write),
    .mem_dq_in(mem_dq_in), .done(done), .rd_data(rd_data)
  );
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              ready,
  input logic              done,
  input logic              last_phase,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready) |=> !ready);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_phase |=> (done && ready));
  // R3
  strobe_inside_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  // R3
  strobe_release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(mem_we_n)) |-> !mem_ce_n);
  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  // R5
  data_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);
  // R6
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe));
endmodule

bind sram_seq sram_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready),
  .done(done), .last_phase(last_phase), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_seq_tb.sv
`timescale 1ns/1ps
module sram_seq_tb;
  localparam int CLK_PERIOD = 20;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam logic [DATA_W-1:0] DECOY = 16'hDEAD;

  // R1: own restatement of the access length
  function automatic int bench_cycles(input int clk_ns, input int rd_ns, input int wr_ns);
    int k;
    k = 1;
    while (k * clk_ns < rd_ns || k * clk_ns < wr_ns) k++;
    if (k < 3) k = 3;
    return k;
  endfunction
  localparam int N = bench_cycles(CLK_PERIOD, 65, 75);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic ready, done, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DATA_W-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic [ADDR_W-1:0] mem_addr;

  int checks = 0, failures = 0;
  logic [DATA_W-1:0] model_mem [16];
  logic [DATA_W-1:0] shadow [16];
  int oe_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // memory model: output valid only after N-1 phases of output enable
  always @(posedge clk) begin
    if (mem_oe_n || mem_ce_n) oe_cnt <= 0;
    else oe_cnt <= oe_cnt + 1;
  end
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && oe_cnt >= N - 1) ? model_mem[mem_addr[3:0]] : DECOY;
  always @(posedge mem_we_n) begin
    if (rst_n && !mem_ce_n && mem_dq_oe) model_mem[mem_addr[3:0]] <= mem_dq_out;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one access; caller is at a negedge with ready high
  task automatic do_access(input bit wr, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d, input bit junk);
    logic [DATA_W-1:0] rd_before;
    logic [DATA_W-1:0] exp_rd;
    rd_before = rd_data;
    exp_rd = shadow[a[3:0]];
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    for (int k = 1; k <= N; k++) begin
      @(negedge clk);
      if (junk && k < N) begin
        req_valid = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
      end else begin
        req_valid = 1'b0;
      end
      chk(ready == 1'b0, "R2", "ready busy", ready, 0);
      chk(mem_ce_n == 1'b0, "R4", "ce_n", mem_ce_n, 0);
      chk(mem_addr == a, "R4", "addr", mem_addr, a);
      if (wr) begin
        chk(mem_we_n == !(k >= 2 && k <= N - 1), "R3", $sformatf("we_n T%0d", k), mem_we_n, !(k >= 2 && k <= N - 1));
        chk(mem_dq_oe && mem_dq_out == d, "R5", "write data", mem_dq_out, d);
      end else begin
        chk(!mem_oe_n && mem_we_n && !mem_dq_oe, "R6", "read pins",
            {mem_oe_n, mem_we_n, mem_dq_oe}, 3'b010);
      end
    end
    @(negedge clk);
    chk(done && ready, "R7", "done+ready", {done, ready}, 2'b11);
    if (wr) begin
      shadow[a[3:0]] = d;
      chk(rd_data == rd_before, "R7", "rd_data kept on write", rd_data, rd_before);
    end else begin
      chk(rd_data == exp_rd, "R6", "rd_data", rd_data, exp_rd);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin model_mem[i] = 16'(i * 3); shadow[i] = 16'(i * 3); end
    void'($urandom(32'd2024));
    #(CLK_PERIOD * 3 + 3);
    // R8 reset state
    chk(ready && !done && rd_data == 0, "R8", "host side", {ready, done}, 2'b10);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R8", "mem side",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(N == 4, "R1", "cycle count", N, 4);
    // directed
    do_access(1'b0, 12'h005, 16'h0, 1'b0);
    do_access(1'b1, 12'h005, 16'hA5C3, 1'b1);
    do_access(1'b0, 12'h005, 16'h0, 1'b1);
    do_access(1'b1, 12'hFFF, 16'hFFFF, 1'b0);
    do_access(1'b0, 12'hFFF, 16'h0, 1'b0);
    // R2: junk ignored, no further access after done
    @(negedge clk);
    chk(mem_ce_n && !done && ready, "R2", "idle after done", {mem_ce_n, done, ready}, 3'b101);
    // random
    for (int i = 0; i < 60; i++) begin
      do_access(1'($urandom), ADDR_W'($urandom), DATA_W'($urandom), 1'($urandom));
      if ($urandom % 3 == 0) @(negedge clk);
    end
    for (int i = 0; i < 16; i++) do_access(1'b0, ADDR_W'(i), 16'h0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule